// File: doc/BRIEF.md
# Saturating rounding fractional multiplier

A lane-parallel multiplier for signed fixed-point fractions. Each of `LANES` lanes takes two signed `SEW`-bit operands, forms the full `2*SEW`-bit product, and returns the product scaled by `2^-(SEW-1)` as one `SEW`-bit fraction. Rounding is to nearest. The only overflow, the most negative value squared, clamps to the most positive value. The second operand is either a full vector or one scalar that is copied to every lane.

A per-lane enable decides which lanes produce a new result. A disabled lane returns the previous destination element, which arrives on a separate bus. The block has a two-stage pipeline: the first stage multiplies, the second rounds, divides and saturates. It takes one operation per cycle on a valid/ready handshake. A sticky flag records every accepted result in which an enabled lane saturated, and it stays set until a clear pulse arrives.

Top module: `frac_mul_sat`

## Requirements
- R1: For a zero or positive product p, an enabled lane returns trunc((p + 2^(SEW-2)) / 2^(SEW-1)). With SEW=16, 1 x 0x4000 gives 1, 3 x 0x4000 gives 2 and 0x7FFF x 0x7FFF gives 0x7FFE.
- R2: For a negative product p, an enabled lane returns (p + 1 - 2^(SEW-2)) / 2^(SEW-1), with the division truncated toward zero and not floored. With SEW=16, -1 x 0x4000 gives 0 and -3 x 0x4000 gives -1.
- R3: An enabled lane whose two operands both equal the most negative value (0x8000 at SEW=16) returns the most positive value (0x7FFF). No other operand pair saturates.
- R4: When `use_scalar_i` is 1, every lane uses `scalar_i` as its second operand in place of its slice of `vs1_i`. Lane g always occupies bits [g*SEW +: SEW] of every vector bus.
- R5: A lane whose bit in `mask_i` is 0 returns its element of `old_i` unchanged.
- R6: `sat_o` becomes 1 in the cycle after the output handshake of a result in which an enabled lane saturated, and then stays at 1. A saturating operand pair in a disabled lane does not set it.
- R7: A `sat_clr_i` pulse clears `sat_o` in the next cycle. If a saturating result completes its handshake in the same cycle as the pulse, the flag ends at 1.
- R8: When `out_ready_i` stays 1, a result is presented on the second clock edge after its input handshake, and a new operation is accepted on every cycle.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and `result_o` does not change.
- R10: After reset, `out_valid_o` and `sat_o` are 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken |
| vs2_i | input | LANES*SEW | First operand vector |
| vs1_i | input | LANES*SEW | Second operand vector |
| scalar_i | input | SEW | Scalar second operand |
| use_scalar_i | input | 1 | 1 selects the scalar broadcast |
| mask_i | input | LANES | Per-lane enable |
| old_i | input | LANES*SEW | Previous destination elements |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | LANES*SEW | Per-lane results |
| sat_clr_i | input | 1 | Clears the sticky flag |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The one collision that matters is a saturating result leaving the output in the same cycle that a clear pulse arrives. Setting must win that collision. A directed sequence sends a vector whose operands are the most negative value in every lane. The bench then raises `sat_clr_i` for exactly the cycle of that result's output handshake. Random traffic with random clear pulses and random output stalls repeats the collision many times. A behavioural flag model, updated with the same priority, is compared with `sat_o` on every cycle.

// File: rtl/frac_mul_pkg.sv
package frac_mul_pkg;
  typedef enum logic {
    SRC_VEC    = 1'b0,
    SRC_SCALAR = 1'b1
  } src_e;
endpackage

// File: rtl/frac_mul_lane_prod.sv
module frac_mul_lane_prod #(
  parameter int SEW = 16
) (
  input  logic [SEW-1:0]             a_i,
  input  logic [SEW-1:0]             b_i,
  output logic signed [2*SEW-1:0]    prod_o,
  output logic                       ovf_o
);
  localparam int PW = 2 * SEW;
  localparam logic [SEW-1:0] MIN_V = {1'b1, {(SEW-1){1'b0}}};

  logic signed [PW-1:0] a_ext, b_ext;

  assign a_ext  = $signed({{SEW{a_i[SEW-1]}}, a_i});
  assign b_ext  = $signed({{SEW{b_i[SEW-1]}}, b_i});
  assign prod_o = a_ext * b_ext;
  // only pair whose product keeps a single sign bit
  assign ovf_o  = (a_i == MIN_V) && (b_i == MIN_V);
endmodule

// File: rtl/frac_mul_lane_rnd.sv
module frac_mul_lane_rnd #(
  parameter int SEW = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic signed [2*SEW-1:0]    prod_i,
  input  logic                       ovf_i,
  input  logic                       act_i,
  input  logic [SEW-1:0]             old_i,
  output logic [SEW-1:0]             res_o
);
  localparam int PW = 2 * SEW;
  localparam logic signed [PW:0] HALF_POS = (PW+1)'(1) << (SEW-2);
  localparam logic signed [PW:0] HALF_NEG = -HALF_POS + (PW+1)'(1);
  localparam logic signed [PW:0] TRUNC_BIAS = ((PW+1)'(1) << (SEW-1)) - (PW+1)'(1);
  localparam logic [SEW-1:0] MAX_V = {1'b0, {(SEW-1){1'b1}}};

  logic signed [PW:0] p_ext, sum, adj, quo;
  logic [SEW-1:0]     res_d;

  assign p_ext = {prod_i[PW-1], prod_i};
  assign sum   = p_ext + (prod_i[PW-1] ? HALF_NEG : HALF_POS);
  // bias negatives so the shift truncates toward zero
  assign adj   = sum[PW] ? sum + TRUNC_BIAS : sum;
  assign quo   = adj >>> (SEW-1);

  always_comb begin
    if (!act_i)     res_d = old_i;
    else if (ovf_i) res_d = MAX_V;
    else            res_d = quo[SEW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_o <= '0;
    else if (en_i) res_o <= res_d;
  end

  // R3: outside the single overflow pair the quotient fits in SEW bits
  p_fits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !ovf_i |-> quo[PW:SEW-1] == {(PW-SEW+2){quo[SEW-1]}});

  p_ovf_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ovf_i && act_i |=> res_o == MAX_V);

  p_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !act_i |=> res_o == $past(old_i));
endmodule

// File: rtl/frac_mul_sat.sv
module frac_mul_sat #(
  parameter int LANES = 4,
  parameter int SEW   = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [LANES*SEW-1:0]   vs2_i,
  input  logic [LANES*SEW-1:0]   vs1_i,
  input  logic [SEW-1:0]         scalar_i,
  input  logic                   use_scalar_i,
  input  logic [LANES-1:0]       mask_i,
  input  logic [LANES*SEW-1:0]   old_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [LANES*SEW-1:0]   result_o,
  input  logic                   sat_clr_i,
  output logic                   sat_o
);
  import frac_mul_pkg::*;
  localparam int PW = 2 * SEW;

  src_e src;
  logic s1_valid_q, s2_valid_q, s2_sat_q, sat_q;
  logic s1_ready, s2_ready, adv1, adv2;
  logic [LANES-1:0] s1_act_q, s1_ovf_q;

  assign src      = src_e'(use_scalar_i);
  assign s2_ready = !s2_valid_q || out_ready_i;
  assign s1_ready = !s1_valid_q || s2_ready;
  assign adv1     = in_valid_i && s1_ready;
  assign adv2     = s1_valid_q && s2_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SEW-1:0]       opb;
    logic signed [PW-1:0] prod_d, prod_q;
    logic                 ovf_d;
    logic [SEW-1:0]       old_q;

    assign opb = (src == SRC_SCALAR) ? scalar_i : vs1_i[g*SEW +: SEW];

    frac_mul_lane_prod #(.SEW(SEW)) i_prod (
      .a_i    (vs2_i[g*SEW +: SEW]),
      .b_i    (opb),
      .prod_o (prod_d),
      .ovf_o  (ovf_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q      <= '0;
        old_q       <= '0;
        s1_ovf_q[g] <= 1'b0;
        s1_act_q[g] <= 1'b0;
      end else if (adv1) begin
        prod_q      <= prod_d;
        old_q       <= old_i[g*SEW +: SEW];
        s1_ovf_q[g] <= ovf_d;
        s1_act_q[g] <= mask_i[g];
      end
    end

    frac_mul_lane_rnd #(.SEW(SEW)) i_rnd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (adv2),
      .prod_i (prod_q),
      .ovf_i  (s1_ovf_q[g]),
      .act_i  (s1_act_q[g]),
      .old_i  (old_q),
      .res_o  (result_o[g*SEW +: SEW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      s2_sat_q   <= 1'b0;
      sat_q      <= 1'b0;
    end else begin
      if (s1_ready) s1_valid_q <= in_valid_i;
      if (s2_ready) s2_valid_q <= s1_valid_q;
      if (adv2)     s2_sat_q   <= |(s1_ovf_q & s1_act_q);
      // set wins over a coincident clear
      if (s2_valid_q && out_ready_i && s2_sat_q) sat_q <= 1'b1;
      else if (sat_clr_i)                        sat_q <= 1'b0;
    end
  end

  assign in_ready_o  = s1_ready;
  assign out_valid_o = s2_valid_q;
  assign sat_o       = sat_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o && !sat_clr_i |=> sat_o);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_clr_i && !(out_valid_o && out_ready_i) |=> !sat_o);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && s2_sat_q |=> sat_o);

  p_no_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
endmodule

// File: tb/test_frac_mul_sat.sv
module test_frac_mul_sat;
  localparam int LANES = 4;
  localparam int SEW   = 16;
  localparam int VW    = LANES * SEW;
  localparam logic [SEW-1:0] MIN_V = {1'b1, {(SEW-1){1'b0}}};
  localparam logic [SEW-1:0] MAX_V = {1'b0, {(SEW-1){1'b1}}};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_ready_o;
  logic [VW-1:0] vs2_i = '0, vs1_i = '0, old_i = '0, result_o;
  logic [SEW-1:0] scalar_i = '0;
  logic use_scalar_i = 1'b0;
  logic [LANES-1:0] mask_i = '0;
  logic out_valid_o, out_ready_i = 1'b1;
  logic sat_clr_i = 1'b0, sat_o;

  always #4 clk_i = ~clk_i;

  frac_mul_sat #(.LANES(LANES), .SEW(SEW)) i_frac_mul_sat (.*);

  typedef struct packed {
    logic [VW-1:0]      exp;
    logic [LANES*4-1:0] tag;
    logic               sat;
    logic               flow;
    logic [31:0]        cyc;
  } ent_t;

  ent_t q[$];
  int nvec = 0, nerr = 0, cyc = 0;
  logic m_sat = 1'b0, flow = 1'b1, held = 1'b0, done = 1'b0;
  logic [VW-1:0] held_val = '0;

  task automatic chk(input logic ok, input int req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SEW-1:0] ref_lane(input logic [SEW-1:0] a, input logic [SEW-1:0] b);
    longint p, nudge, qq;
    if (a == MIN_V && b == MIN_V) return MAX_V;
    p = longint'($signed(a)) * longint'($signed(b));
    nudge = (p >= 0) ? (longint'(1) <<< (SEW-2)) : (1 - (longint'(1) <<< (SEW-2)));
    qq = (p + nudge) / (longint'(1) <<< (SEW-1));
    return qq[SEW-1:0];
  endfunction

  // tags: 1=R1 pos, 2=R2 neg, 3=R3 sat, 4=R4 scalar, 5=R5 masked
  function automatic ent_t model();
    ent_t e;
    e = '0;
    for (int g = 0; g < LANES; g++) begin
      logic [SEW-1:0] a, b;
      longint p;
      a = vs2_i[g*SEW +: SEW];
      b = use_scalar_i ? scalar_i : vs1_i[g*SEW +: SEW];
      p = longint'($signed(a)) * longint'($signed(b));
      if (!mask_i[g]) begin
        e.exp[g*SEW +: SEW] = old_i[g*SEW +: SEW];
        e.tag[g*4 +: 4] = 4'd5;
      end else begin
        e.exp[g*SEW +: SEW] = ref_lane(a, b);
        if (a == MIN_V && b == MIN_V) begin
          e.tag[g*4 +: 4] = 4'd3;
          e.sat = 1'b1;
        end else if (use_scalar_i) e.tag[g*4 +: 4] = 4'd4;
        else if (p < 0)            e.tag[g*4 +: 4] = 4'd2;
        else                       e.tag[g*4 +: 4] = 4'd1;
      end
    end
    e.flow = flow;
    e.cyc  = cyc;
    return e;
  endfunction

  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && !done) begin
      logic nxt;
      chk(sat_o == m_sat, 6, VW'(sat_o), VW'(m_sat)); // R6 / R7 flag model
      nxt = m_sat;
      if (held) chk(out_valid_o && result_o == held_val, 9, result_o, held_val); // R9
      held = out_valid_o && !out_ready_i;
      held_val = result_o;
      if (in_valid_i && in_ready_o) q.push_back(model());
      if (out_valid_o && out_ready_i) begin
        if (q.size() == 0) chk(1'b0, 8, result_o, '0);
        else begin
          ent_t e;
          e = q.pop_front();
          for (int g = 0; g < LANES; g++)
            chk(result_o[g*SEW +: SEW] == e.exp[g*SEW +: SEW], int'(e.tag[g*4 +: 4]),
                VW'(result_o[g*SEW +: SEW]), VW'(e.exp[g*SEW +: SEW]));
          if (e.flow && flow) chk(cyc - int'(e.cyc) == 2, 8, VW'(cyc - int'(e.cyc)), VW'(2)); // R8
          if (e.sat) nxt = 1'b1;
          else if (sat_clr_i) nxt = 1'b0;
        end
      end else if (sat_clr_i) nxt = 1'b0;
      m_sat = nxt;
    end
  end

  task automatic send(input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [SEW-1:0] sc,
                      input logic us, input logic [LANES-1:0] m, input logic [VW-1:0] o);
    vs2_i = a; vs1_i = b; scalar_i = sc; use_scalar_i = us; mask_i = m; old_i = o;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    @(posedge clk_i); #2;
    in_valid_i = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk_i);
    while (q.size() != 0 || out_valid_o) @(negedge clk_i);
    @(posedge clk_i); #2;
  endtask

  function automatic logic [SEW-1:0] rnd_op();
    case ($urandom % 5)
      0:       return MIN_V;
      1:       return MAX_V;
      2:       return SEW'($urandom % 8) - SEW'(4);
      3:       return SEW'(1) << (SEW-2);
      default: return SEW'($urandom);
    endcase
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int g = 0; g < LANES; g++) v[g*SEW +: SEW] = rnd_op();
    return v;
  endfunction

  logic rnd_ready = 1'b0;
  initial begin
    forever begin
      @(posedge clk_i); #2;
      if (rnd_ready) out_ready_i = ($urandom % 3) != 0;
      else           out_ready_i = 1'b1;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R10: reset state
    chk(!out_valid_o, 10, VW'(out_valid_o), '0);
    chk(!sat_o, 10, VW'(sat_o), '0);
    chk(in_ready_o, 10, VW'(in_ready_o), VW'(1));
    @(posedge clk_i); #2;

    // R1: positive rounding, halves upward
    send({16'h7FFF, 16'h0003, 16'h4000, 16'h0001}, {16'h7FFF, 16'h4000, 16'h4000, 16'h4000}, '0, 1'b0, 4'hF, '0);
    // R2: negatives truncate toward zero after nudge
    send({16'h8000, 16'hFFFE, 16'hFFFD, 16'hFFFF}, {16'h7FFF, 16'h4000, 16'h4000, 16'h4000}, '0, 1'b0, 4'hF, '0);
    // R5: masked lanes keep old elements
    send({16'h1234, 16'h8000, 16'h7FFF, 16'h0101}, {16'h2222, 16'h8000, 16'h7FFF, 16'h0202}, '0, 1'b0, 4'b1001,
         {16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD});
    drain();
    // R6: inactive overflow lanes must leave the flag low
    chk(!sat_o, 6, VW'(sat_o), '0);

    // R3 and R7: saturating result meets a clear pulse in its handshake cycle
    send({LANES{MIN_V}}, {LANES{MIN_V}}, '0, 1'b0, 4'hF, '0);
    @(posedge clk_i); #2; sat_clr_i = 1'b1;
    @(posedge clk_i); #2; sat_clr_i = 1'b0;
    @(negedge clk_i);
    chk(sat_o, 7, VW'(sat_o), VW'(1));
    @(posedge clk_i); #2; sat_clr_i = 1'b1;
    @(posedge clk_i); #2; sat_clr_i = 1'b0;
    @(negedge clk_i);
    chk(!sat_o, 7, VW'(sat_o), '0);
    @(posedge clk_i); #2;

    // R4: scalar broadcast
    send({16'h8000, 16'h4000, 16'hC000, 16'h0001}, '1, MIN_V, 1'b1, 4'hF, '0);
    send({16'h7FFF, 16'h0003, 16'hFFFD, 16'h2000}, '0, 16'h4000, 1'b1, 4'hF, '0);

    // R8: back-to-back random traffic, consumer always ready
    for (int i = 0; i < 300; i++) begin
      sat_clr_i = ($urandom % 8) == 0;
      send(rnd_vec(), rnd_vec(), rnd_op(), 1'($urandom), LANES'($urandom), VW'({$urandom, $urandom}));
    end
    sat_clr_i = 1'b0;
    drain();

    // R9: random output stalls
    flow = 1'b0;
    rnd_ready = 1'b1;
    for (int i = 0; i < 600; i++) begin
      sat_clr_i = ($urandom % 6) == 0;
      send(rnd_vec(), rnd_vec(), rnd_op(), 1'($urandom), LANES'($urandom), VW'({$urandom, $urandom}));
    end
    sat_clr_i = 1'b0;
    rnd_ready = 1'b0;
    drain();
    repeat (4) @(negedge clk_i);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      nvec++;
      nerr++;
      $display("FAIL R8 actual=hung expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule